// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Interface

This block sits between a byte-wide host bus and the two serial channels of an asynchronous serial controller. It decodes a 4-bit address under active-low chip-enable, read and write strobes. It holds the configuration registers for both channels and for the shared functions, returns read data from status, input and counter sources supplied on side ports, and turns certain accesses into one-cycle pulses for the FIFOs, the counter/timer and the channel enable logic.

One address can mean different registers for reads and for writes. Each channel keeps three mode bytes behind a single address. A per-channel pointer selects which byte an access reaches. The pointer advances on every access to that address, stops at the third byte, and is reloaded only by a channel command. Reads of some addresses and writes of others are actions rather than storage: a FIFO pop, a FIFO push, counter start or stop, and setting or clearing output-port bits.

An access is taken once, on the first clock edge at which chip-enable and its strobe are both low. The serial engines, FIFOs, baud generator and counter/timer are outside this block and connect through the side ports.

Top module: `duart_hostregs`

## Requirements
- R1: After reset, both mode pointers select mode byte 1. All stored registers and the output port are zero, and every pulse output is low.
- R2: A channel mode address (0x0 for channel A, 0x8 for channel B) reads or writes the mode byte chosen by that channel's pointer. Each taken access advances the pointer by one, up to byte 2, and the pointer stays at 2 on further accesses.
- R3: A write to a channel command address (0x2 for A, 0xA for B) with upper nibble 0x1 sets that channel's pointer to 1. Upper nibble 0xB sets it to 0. Any other upper nibble leaves the pointer unchanged.
- R4: Each command write gives a one-cycle command strobe for its channel and presents the upper nibble. It also gives one-cycle pulses from the lower nibble: bit 0 receiver enable, bit 1 receiver disable, bit 2 transmitter enable, bit 3 transmitter disable.
- R5: Channel B (0x8–0xB) behaves like channel A (0x0–0x3) with its own registers and pointer. An access to one channel leaves the other channel unchanged.
- R6: Writes to 0x4, 0x5, 0x6, 0x7, 0xC and 0xD store auxiliary control, interrupt mask, counter preset upper, counter preset lower, vector and output configuration, in that order. A read of 0xC returns the vector.
- R7: Reads return the channel status at 0x1/0x9, input change at 0x4, interrupt status at 0x5, counter upper byte at 0x6, counter lower byte at 0x7 and input port at 0xD.
- R8: A write to 0x3/0xB gives a one-cycle push pulse for that channel, with the written byte on the transmit data output. A read of 0x3/0xB returns that channel's received byte and gives a one-cycle pop pulse.
- R9: A read of 0xE gives a one-cycle counter-start pulse and a read of 0xF gives a one-cycle counter-stop pulse. Both reads return zero.
- R10: A write to 0xE sets each output-port bit whose data bit is 1. A write to 0xF clears each output-port bit whose data bit is 1. Bits written as 0 are unchanged.
- R11: A read of 0x2 or 0xA returns zero, gives no pulse and does not move either pointer.
- R12: A strobe held low for several cycles counts as one access: one pointer advance or one pulse.
- R13: Read data is zero whenever chip-enable or the read strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| chan_status | input | 2x8 | Per-channel status byte |
| rx_byte_in | input | 2x8 | Per-channel received byte at FIFO head |
| in_change | input | 8 | Input change byte |
| irq_status | input | 8 | Interrupt status byte |
| ctr_value | input | 16 | Counter/timer current value |
| in_port | input | 8 | Input port levels |
| mode_regs | output | 2x3x8 | Mode bytes per channel |
| clk_sel | output | 2x8 | Clock select per channel |
| cmd_stb | output | 2 | Command strobe per channel |
| cmd_op | output | 2x4 | Command upper nibble per channel |
| rx_en_p | output | 2 | Receiver enable pulse |
| rx_dis_p | output | 2 | Receiver disable pulse |
| tx_en_p | output | 2 | Transmitter enable pulse |
| tx_dis_p | output | 2 | Transmitter disable pulse |
| tx_push | output | 2 | Transmit FIFO push pulse |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 2 | Receive FIFO pop pulse |
| ctr_start | output | 1 | Counter start pulse |
| ctr_stop | output | 1 | Counter stop pulse |
| aux_ctrl | output | 8 | Auxiliary control |
| irq_mask | output | 8 | Interrupt mask |
| ctr_preset | output | 16 | Counter preset |
| vec_reg | output | 8 | Interrupt vector |
| outcfg | output | 8 | Output configuration |
| out_port | output | 8 | Output port bits |

## Verification
The hardest state to reach is the one the pointer enters after a long history. Showing saturation takes three accesses in a row to the mode address. Showing a reload takes a command write after that, followed by reads that walk the pointer forward again, so that the byte returned shows where the pointer ended up. The stimulus holds the read strobe low over several edges and then reads again. Only the value returned on that later read shows whether the held strobe gave one advance or several. The reserved-address case is checked the same way: a read of the command address is followed by a mode read whose value proves the pointer did not move.

// File: rtl/duart_hif_pkg.sv
package duart_hif_pkg;
  localparam int DW     = 8;
  localparam int NMODE  = 3;
  localparam int PTRW   = 2;
  // offsets within a channel window
  localparam logic [1:0] OFS_MODE = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_FIFO = 2'd3;
  // command upper nibbles that reload the mode pointer
  localparam logic [3:0] CMD_PTR1 = 4'h1;
  localparam logic [3:0] CMD_PTR0 = 4'hB;
  typedef struct packed {
    logic mode_rd;
    logic mode_wr;
    logic csr_wr;
    logic cmd_wr;
    logic tx_wr;
    logic rx_rd;
  } chan_sel_t;
endpackage

// File: rtl/duart_hif_access.sv
module duart_hif_access (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_active,
  output logic rd_take,
  output logic wr_take
);
  logic wr_active;
  logic prev_rd_q, prev_wr_q;

  always_comb begin
    rd_active = !cs_n && !rd_n;
    wr_active = !cs_n && !wr_n;
    rd_take   = rd_active && !prev_rd_q;
    wr_take   = wr_active && !prev_wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q <= 1'b0;
      prev_wr_q <= 1'b0;
    end else begin
      prev_rd_q <= rd_active;
      prev_wr_q <= wr_active;
    end
  end

  // R12: a held strobe is taken only once
  p_single_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> !rd_take);
  p_single_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !wr_take);
endmodule

// File: rtl/duart_hif_chan.sv
module duart_hif_chan
  import duart_hif_pkg::*;
#(
  parameter int W = DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  chan_sel_t                sel,
  input  logic [W-1:0]             wdata,
  output logic [NMODE-1:0][W-1:0]  mode_q,
  output logic [W-1:0]             mode_rd,
  output logic [W-1:0]             csr_q,
  output logic                     cmd_stb,
  output logic [3:0]               cmd_op,
  output logic                     rx_en_p,
  output logic                     rx_dis_p,
  output logic                     tx_en_p,
  output logic                     tx_dis_p,
  output logic                     tx_push,
  output logic                     rx_pop
);
  localparam logic [PTRW-1:0] PTR_TOP = PTRW'(NMODE - 1);

  logic [PTRW-1:0] ptr_q, ptr_d;
  logic            ptr_en;
  logic [3:0]      op_d;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (sel.cmd_wr) begin
      if (wdata[7:4] == CMD_PTR1) begin
        ptr_d  = PTRW'(1);
        ptr_en = 1'b1;
      end else if (wdata[7:4] == CMD_PTR0) begin
        ptr_d  = '0;
        ptr_en = 1'b1;
      end
    end else if ((sel.mode_rd || sel.mode_wr) && ptr_q != PTR_TOP) begin
      ptr_d  = ptr_q + 1'b1;
      ptr_en = 1'b1;
    end
    op_d    = sel.cmd_wr ? wdata[7:4] : cmd_op;
    mode_rd = mode_q[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PTRW'(1);
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    logic mwe;
    assign mwe = sel.mode_wr && (ptr_q == PTRW'(m));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[m] <= '0;
      else if (mwe) mode_q[m] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q    <= '0;
      cmd_op   <= '0;
      cmd_stb  <= 1'b0;
      rx_en_p  <= 1'b0;
      rx_dis_p <= 1'b0;
      tx_en_p  <= 1'b0;
      tx_dis_p <= 1'b0;
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
    end else begin
      if (sel.csr_wr) csr_q <= wdata;
      cmd_op   <= op_d;
      cmd_stb  <= sel.cmd_wr;
      rx_en_p  <= sel.cmd_wr && wdata[0];
      rx_dis_p <= sel.cmd_wr && wdata[1];
      tx_en_p  <= sel.cmd_wr && wdata[2];
      tx_dis_p <= sel.cmd_wr && wdata[3];
      tx_push  <= sel.tx_wr;
      rx_pop   <= sel.rx_rd;
    end
  end

  // R2: the pointer never leaves the three mode bytes and saturates at the top
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_TOP);
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == PTR_TOP && !sel.cmd_wr) |=> ptr_q == PTR_TOP);
  // R3: reload commands
  p_cmd_ptr1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.cmd_wr && wdata[7:4] == CMD_PTR1) |=> ptr_q == PTRW'(1));
  p_cmd_ptr0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.cmd_wr && wdata[7:4] == CMD_PTR0) |=> ptr_q == '0);
  // R4: enable/disable pulses only come with a command strobe
  p_en_with_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_p || rx_dis_p || tx_en_p || tx_dis_p) |-> cmd_stb);
endmodule

// File: rtl/duart_hif_shared.sv
module duart_hif_shared
  import duart_hif_pkg::*;
#(
  parameter int W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_take,
  input  logic           wr_take,
  input  logic [3:0]     addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   aux_ctrl,
  output logic [W-1:0]   irq_mask,
  output logic [2*W-1:0] ctr_preset,
  output logic [W-1:0]   vec_reg,
  output logic [W-1:0]   outcfg,
  output logic [W-1:0]   out_port,
  output logic           ctr_start,
  output logic           ctr_stop
);
  logic we_aux, we_imr, we_pu, we_pl, we_vec, we_cfg, we_set, we_clr;
  logic [W-1:0] port_d;
  logic         port_en;

  always_comb begin
    we_aux  = wr_take && addr == 4'h4;
    we_imr  = wr_take && addr == 4'h5;
    we_pu   = wr_take && addr == 4'h6;
    we_pl   = wr_take && addr == 4'h7;
    we_vec  = wr_take && addr == 4'hC;
    we_cfg  = wr_take && addr == 4'hD;
    we_set  = wr_take && addr == 4'hE;
    we_clr  = wr_take && addr == 4'hF;
    port_en = we_set || we_clr;
    port_d  = we_set ? (out_port | wdata) : (out_port & ~wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_ctrl   <= '0;
      irq_mask   <= '0;
      ctr_preset <= '0;
      vec_reg    <= '0;
      outcfg     <= '0;
      out_port   <= '0;
      ctr_start  <= 1'b0;
      ctr_stop   <= 1'b0;
    end else begin
      if (we_aux)  aux_ctrl <= wdata;
      if (we_imr)  irq_mask <= wdata;
      if (we_pu)   ctr_preset[2*W-1:W] <= wdata;
      if (we_pl)   ctr_preset[W-1:0]   <= wdata;
      if (we_vec)  vec_reg  <= wdata;
      if (we_cfg)  outcfg   <= wdata;
      if (port_en) out_port <= port_d;
      ctr_start <= rd_take && addr == 4'hE;
      ctr_stop  <= rd_take && addr == 4'hF;
    end
  end

  // R10: set write raises every selected bit, clear write drops it
  p_set_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((out_port & $past(wdata)) == $past(wdata)));
  p_clr_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((out_port & $past(wdata)) == '0));
  // R9: one counter action per access
  p_start_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctr_start && ctr_stop));
endmodule

// File: rtl/duart_hostregs.sv
module duart_hostregs
  import duart_hif_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic [3:0]                 addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  input  logic [1:0][DW-1:0]         chan_status,
  input  logic [1:0][DW-1:0]         rx_byte_in,
  input  logic [DW-1:0]              in_change,
  input  logic [DW-1:0]              irq_status,
  input  logic [2*DW-1:0]            ctr_value,
  input  logic [DW-1:0]              in_port,
  output logic [1:0][NMODE-1:0][DW-1:0] mode_regs,
  output logic [1:0][DW-1:0]         clk_sel,
  output logic [1:0]                 cmd_stb,
  output logic [1:0][3:0]            cmd_op,
  output logic [1:0]                 rx_en_p,
  output logic [1:0]                 rx_dis_p,
  output logic [1:0]                 tx_en_p,
  output logic [1:0]                 tx_dis_p,
  output logic [1:0]                 tx_push,
  output logic [DW-1:0]              tx_byte,
  output logic [1:0]                 rx_pop,
  output logic                       ctr_start,
  output logic                       ctr_stop,
  output logic [DW-1:0]              aux_ctrl,
  output logic [DW-1:0]              irq_mask,
  output logic [2*DW-1:0]            ctr_preset,
  output logic [DW-1:0]              vec_reg,
  output logic [DW-1:0]              outcfg,
  output logic [DW-1:0]              out_port
);
  logic rst_m, rst_s;
  logic rd_active, rd_take, wr_take, tx_any;
  logic [1:0][DW-1:0] mode_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  duart_hif_access u_acc (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_active(rd_active), .rd_take(rd_take), .wr_take(wr_take)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    chan_sel_t sel;
    logic      hit;
    assign hit = (addr[3] == c[0]) && !addr[2];
    always_comb begin
      sel.mode_rd = rd_take && hit && addr[1:0] == OFS_MODE;
      sel.mode_wr = wr_take && hit && addr[1:0] == OFS_MODE;
      sel.csr_wr  = wr_take && hit && addr[1:0] == OFS_STAT;
      sel.cmd_wr  = wr_take && hit && addr[1:0] == OFS_CMD;
      sel.tx_wr   = wr_take && hit && addr[1:0] == OFS_FIFO;
      sel.rx_rd   = rd_take && hit && addr[1:0] == OFS_FIFO;
    end
    duart_hif_chan #(.W(DW)) u_chan (
      .clk(clk), .rst_n(rst_s), .sel(sel), .wdata(wdata),
      .mode_q(mode_regs[c]), .mode_rd(mode_rd[c]), .csr_q(clk_sel[c]),
      .cmd_stb(cmd_stb[c]), .cmd_op(cmd_op[c]),
      .rx_en_p(rx_en_p[c]), .rx_dis_p(rx_dis_p[c]),
      .tx_en_p(tx_en_p[c]), .tx_dis_p(tx_dis_p[c]),
      .tx_push(tx_push[c]), .rx_pop(rx_pop[c])
    );
  end

  duart_hif_shared #(.W(DW)) u_shared (
    .clk(clk), .rst_n(rst_s), .rd_take(rd_take), .wr_take(wr_take),
    .addr(addr), .wdata(wdata), .aux_ctrl(aux_ctrl), .irq_mask(irq_mask),
    .ctr_preset(ctr_preset), .vec_reg(vec_reg), .outcfg(outcfg),
    .out_port(out_port), .ctr_start(ctr_start), .ctr_stop(ctr_stop)
  );

  assign tx_any = wr_take && !addr[2] && addr[1:0] == OFS_FIFO;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) tx_byte <= '0;
    else if (tx_any) tx_byte <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd_active) begin
      unique case (addr)
        4'h0: rdata = mode_rd[0];
        4'h1: rdata = chan_status[0];
        4'h3: rdata = rx_byte_in[0];
        4'h4: rdata = in_change;
        4'h5: rdata = irq_status;
        4'h6: rdata = ctr_value[2*DW-1:DW];
        4'h7: rdata = ctr_value[DW-1:0];
        4'h8: rdata = mode_rd[1];
        4'h9: rdata = chan_status[1];
        4'hB: rdata = rx_byte_in[1];
        4'hC: rdata = vec_reg;
        4'hD: rdata = in_port;
        default: rdata = '0;
      endcase
    end
  end

  // R13: bus idle reads zero
  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_n || rd_n) |-> rdata == '0);
  // R8: at most one channel pops or pushes per access
  p_pop_onehot_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(rx_pop) && $onehot0(tx_push));
  // R11: reserved reads cause no pulse
  p_rsvd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_take && addr[1:0] == OFS_CMD && !addr[2]) |=>
      (rx_pop == '0 && !ctr_start && !ctr_stop && cmd_stb == '0));
endmodule

// File: tb/duart_hostregs_bench.sv
module duart_hostregs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0][7:0] chan_status = '0, rx_byte_in = '0;
  logic [7:0] in_change = '0, irq_status = '0, in_port = '0;
  logic [15:0] ctr_value = '0;
  logic [1:0][2:0][7:0] mode_regs;
  logic [1:0][7:0] clk_sel;
  logic [1:0] cmd_stb, rx_en_p, rx_dis_p, tx_en_p, tx_dis_p, tx_push, rx_pop;
  logic [1:0][3:0] cmd_op;
  logic [7:0] tx_byte, aux_ctrl, irq_mask, vec_reg, outcfg, out_port;
  logic [15:0] ctr_preset;
  logic ctr_start, ctr_stop;

  always #5 clk = ~clk;

  duart_hostregs u_duart_hostregs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .chan_status(chan_status),
    .rx_byte_in(rx_byte_in), .in_change(in_change), .irq_status(irq_status),
    .ctr_value(ctr_value), .in_port(in_port), .mode_regs(mode_regs),
    .clk_sel(clk_sel), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .rx_en_p(rx_en_p),
    .rx_dis_p(rx_dis_p), .tx_en_p(tx_en_p), .tx_dis_p(tx_dis_p),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .ctr_start(ctr_start), .ctr_stop(ctr_stop), .aux_ctrl(aux_ctrl),
    .irq_mask(irq_mask), .ctr_preset(ctr_preset), .vec_reg(vec_reg),
    .outcfg(outcfg), .out_port(out_port)
  );

  int checks = 0, errors = 0;
  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];
  event rd_ev;
  // pulse snapshot, taken in the cycle after the taking edge
  logic [1:0] s_stb, s_rxe, s_rxd, s_txe, s_txd, s_push, s_pop;
  logic s_start, s_stop;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the bus
  initial forever begin
    @(rd_ev);
    if (sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      chk(it.tag, {24'h0, rdata}, {24'h0, it.exp});
    end
  end

  task automatic snap();
    s_stb = cmd_stb; s_rxe = rx_en_p; s_rxd = rx_dis_p; s_txe = tx_en_p;
    s_txd = tx_dis_p; s_push = tx_push; s_pop = rx_pop;
    s_start = ctr_start; s_stop = ctr_stop;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    sb.push_back('{exp, tag});
    -> rd_ev;
    @(negedge clk);
    snap();
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    snap();
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R13 idle bus
    chk("R1 out_port", out_port, 0);
    chk("R1 mode", mode_regs, 0);
    chk("R1 pulses", {cmd_stb, rx_pop, tx_push, ctr_start, ctr_stop}, 0);
    chk("R13 idle rdata", rdata, 0);
    // R1 pointer starts at 1; R2 advance and saturation
    wr(4'h0, 8'h11);
    chk("R1 first write to MR1", mode_regs[0][1], 8'h11);
    wr(4'h0, 8'h22);
    chk("R2 second write to MR2", mode_regs[0][2], 8'h22);
    wr(4'h0, 8'h33);
    chk("R2 saturated write", mode_regs[0][2], 8'h33);
    chk("R2 MR0 untouched", mode_regs[0][0], 8'h00);
    // R3 reload to 0 then walk
    wr(4'h2, 8'hB0);
    rd(4'h0, 8'h00, "R3 reload0 reads MR0");
    rd(4'h0, 8'h11, "R2 read MR1");
    rd(4'h0, 8'h33, "R2 read MR2");
    rd(4'h0, 8'h33, "R2 read saturates");
    wr(4'h2, 8'h10);
    rd(4'h0, 8'h11, "R3 reload1 reads MR1");
    wr(4'h2, 8'h20);
    rd(4'h0, 8'h33, "R3 other command keeps pointer");
    // R4 command pulses, bit0 rx en, bit2 tx en
    wr(4'h2, 8'h15);
    chk("R4 stb", s_stb, 2'b01);
    chk("R4 op", cmd_op[0], 4'h1);
    chk("R4 rx en/tx en", {s_rxe, s_txe, s_rxd, s_txd}, 8'b01010000);
    @(negedge clk);
    chk("R4 pulses one cycle", {cmd_stb, rx_en_p, tx_en_p}, 0);
    // R5 channel B
    wr(4'h8, 8'h44);
    chk("R5 B MR1", mode_regs[1][1], 8'h44);
    chk("R5 A untouched", mode_regs[0][1], 8'h11);
    wr(4'hA, 8'hBA);
    chk("R5 B cmd pulses", {s_stb, s_rxd, s_txd, s_rxe, s_txe}, 10'b1010100000);
    rd(4'h8, 8'h00, "R5 B reload0");
    wr(4'h9, 8'hC3);
    chk("R5 B clock select", clk_sel[1], 8'hC3);
    chk("R5 A clock select", clk_sel[0], 8'h00);
    // R6 shared writes
    wr(4'h4, 8'h5A); wr(4'h5, 8'hA5); wr(4'h6, 8'h12); wr(4'h7, 8'h34);
    wr(4'hC, 8'h77); wr(4'hD, 8'h0F);
    chk("R6 aux", aux_ctrl, 8'h5A);
    chk("R6 mask", irq_mask, 8'hA5);
    chk("R6 preset", ctr_preset, 16'h1234);
    chk("R6 cfg", outcfg, 8'h0F);
    rd(4'hC, 8'h77, "R6 vector readback");
    // R7 read map
    chan_status = {8'hB1, 8'hA1}; in_change = 8'h4C; irq_status = 8'h5D;
    ctr_value = 16'hBEEF; in_port = 8'h3E;
    rd(4'h1, 8'hA1, "R7 status A");
    rd(4'h9, 8'hB1, "R7 status B");
    rd(4'h4, 8'h4C, "R7 input change");
    rd(4'h5, 8'h5D, "R7 irq status");
    rd(4'h6, 8'hBE, "R7 counter upper");
    rd(4'h7, 8'hEF, "R7 counter lower");
    rd(4'hD, 8'h3E, "R7 input port");
    // R8 FIFO access
    wr(4'h3, 8'h9C);
    chk("R8 push A", s_push, 2'b01);
    chk("R8 tx byte", tx_byte, 8'h9C);
    wr(4'hB, 8'h6D);
    chk("R8 push B", s_push, 2'b10);
    rx_byte_in = {8'h62, 8'h61};
    rd(4'h3, 8'h61, "R8 rx byte A");
    chk("R8 pop A", s_pop, 2'b01);
    rd(4'hB, 8'h62, "R8 rx byte B");
    chk("R8 pop B", s_pop, 2'b10);
    // R9 counter commands
    rd(4'hE, 8'h00, "R9 start reads zero");
    chk("R9 start pulse", {s_start, s_stop}, 2'b10);
    rd(4'hF, 8'h00, "R9 stop reads zero");
    chk("R9 stop pulse", {s_start, s_stop}, 2'b01);
    // R10 output port set/clear
    wr(4'hE, 8'h81);
    chk("R10 set", out_port, 8'h81);
    wr(4'hE, 8'h02);
    chk("R10 set keeps others", out_port, 8'h83);
    wr(4'hF, 8'h01);
    chk("R10 clear", out_port, 8'h82);
    // R11 reserved reads: A pointer at 1 after the 0x15 command? it was moved to 1, then untouched
    rd(4'h2, 8'h00, "R11 reserved A zero");
    chk("R11 no pulses", {s_stb, s_pop, s_start, s_stop}, 0);
    rd(4'hA, 8'h00, "R11 reserved B zero");
    rd(4'h0, 8'h11, "R11 A pointer unmoved");
    // R12 held strobe: one advance only
    wr(4'h2, 8'hB0);
    wr(4'h0, 8'h5E);
    chk("R12 MR0 write", mode_regs[0][0], 8'h5E);
    wr(4'h2, 8'hB0);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 4'h0;
    #1;
    sb.push_back('{8'h5E, "R12 held read first byte"});
    -> rd_ev;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    rd(4'h0, 8'h11, "R12 single advance");
    wr(4'h3, 8'h01);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 4'h3; wdata = 8'h02;
    @(negedge clk);
    chk("R12 held write first push", tx_push, 2'b01);
    @(negedge clk);
    chk("R12 held write no repeat", tx_push, 2'b00);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R13 rdata after release", rdata, 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule